// File: doc/BRIEF.md
# Synchronizable Integer Clock Divider

This block divides a fast input clock by an integer N between 1 and 8. The divided clock comes out as a one-cycle enable strobe, `div_strobe`, which fires once every N input cycles. Downstream logic keeps running on the fast clock and uses the strobe as a clock enable.

A single configuration write sets three things: the division ratio, whether the external alignment input is honoured, and how it is honoured. The alignment input, `sync_in`, may be asynchronous. A qualified rising edge on it returns the divider to its starting phase. Several dividers that share one `sync_in` line therefore produce coincident strobes. The alignment can act on every rising edge. It can instead act only on the first rising edge after a configuration write, and the `sync_armed` output shows whether that single alignment is still pending.

The block also drives `stab_en`, a flag for a downstream duty-cycle stabilizer. The flag is forced high whenever the programmed ratio is not 1.

Top module: `sync_clk_divider`

## Requirements
- R1: A write with `cfg_we` high loads `cfg_wdata[2:0]` as the ratio code, where N = code + 1 (code 0 is divide by 1, code 7 is divide by 8). Once the ratio is in effect, `div_strobe` is high for one cycle in every N.
- R2: With code 0, `div_strobe` is high on every cycle, whatever `sync_in` does.
- R3: `stab_en` is high exactly when the programmed ratio code is non-zero. It reflects a write from the first cycle after the write edge.
- R4: `sync_in` passes through a two-flop synchronizer and acts only on its rising edge. A level that stays high is one event, so the strobe period stays N while the level is held.
- R5: A qualified sync event resets the divider phase. If `sync_in` is raised just before clock edge k, the next strobe follows edge k+N+1, which is N+2 edges after the raise.
- R6: While `cfg_wdata[3]` (sync enable) is 0 in the active configuration, rising edges on `sync_in` have no effect on the strobe phase.
- R7: With `cfg_wdata[4]` = 0 (every-edge mode), every qualified rising edge realigns the divider.
- R8: With `cfg_wdata[4]` = 1 (first-only mode), only the first rising edge after a configuration write realigns the divider. Later edges are ignored until the next write, which re-arms the mode.
- R9: `sync_armed` is 0 after reset and 1 from the cycle after any configuration write. It returns to 0 once a first-only alignment has been applied.
- R10: A ratio change waits for the current period to end (or for a sync reset). The period in progress keeps its old length and no shortened period is produced.
- R11: After reset, the ratio code is 0 and sync handling is disabled, so `div_strobe` is 1, `stab_en` is 0 and `sync_armed` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | [2:0] ratio code, [3] sync enable, [4] first-only mode |
| sync_in | input | 1 | Asynchronous alignment input |
| div_strobe | output | 1 | Divided clock as a one-cycle enable |
| stab_en | output | 1 | Stabilizer enable, high for any ratio other than 1 |
| sync_armed | output | 1 | A first-only alignment is still pending |

## Verification
- A behavioural model in the bench follows the same timing and is compared with all three outputs at every falling edge.
- A configuration write shows on `stab_en` and `sync_armed` at the first falling edge after the capturing clock edge.
- A raise of `sync_in` takes effect at the third rising edge. The first realigned strobe is therefore seen N+2 edges after the raise.
- Ratio changes are due only after the current period ends.
- The directed checks raise `sync_in` at the falling edge where a strobe has just been seen. They then count edges to the next strobe. An applied alignment gives N+2 edges and an ignored one gives N, and these two counts differ for every N of 3 or more.

// File: rtl/csd_pkg.sv
package csd_pkg;

   typedef enum logic {
      SYNC_EVERY = 1'b0,
      SYNC_FIRST = 1'b1
   } sync_mode_e;

   // Field offsets inside the configuration word, relative to the ratio width
   function automatic int en_bit(input int ratio_w);
      return ratio_w;
   endfunction

   function automatic int mode_bit(input int ratio_w);
      return ratio_w + 1;
   endfunction

endpackage

// File: rtl/csd_sync_edge.sv
module csd_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_o
);

   initial begin
      assert (STAGES >= 2) else $error("csd_sync_edge: STAGES must be at least 2");
   end

   // STAGES synchronizing flops plus one history flop for edge detection
   for (genvar i = 0; i <= STAGES; i++) begin : g_stg
      logic q;
      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= async_in;
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= g_stg[i-1].q;
         end
      end
   end

   assign rise_o = g_stg[STAGES-1].q & ~g_stg[STAGES].q;

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o); // R4

endmodule

// File: rtl/csd_ctrl.sv
module csd_ctrl
   import csd_pkg::*;
#(
   parameter int RATIO_W = 3,
   localparam int CFG_W  = RATIO_W + 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [CFG_W-1:0]   cfg_wdata,
   input  logic               sync_rise,
   output logic [RATIO_W-1:0] ratio_code,
   output logic               sync_fire,
   output logic               armed,
   output logic               stab_en
);

   localparam int EN_B   = en_bit(RATIO_W);
   localparam int MODE_B = mode_bit(RATIO_W);

   logic [RATIO_W-1:0] ratio_q;
   logic               en_q;
   sync_mode_e         mode_q;
   logic               armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ratio_q <= '0;
         en_q    <= 1'b0;
         mode_q  <= SYNC_EVERY;
      end else if (cfg_we) begin
         ratio_q <= cfg_wdata[RATIO_W-1:0];
         en_q    <= cfg_wdata[EN_B];
         mode_q  <= sync_mode_e'(cfg_wdata[MODE_B]);
      end
   end

   // A write re-arms; an applied first-only alignment disarms
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                armed_q <= 1'b0;
      else if (cfg_we)                           armed_q <= 1'b1;
      else if (sync_fire && mode_q == SYNC_FIRST) armed_q <= 1'b0;
   end

   assign sync_fire  = sync_rise & en_q & ((mode_q == SYNC_EVERY) | armed_q);
   assign ratio_code = ratio_q;
   assign armed      = armed_q;
   assign stab_en    = |ratio_q;

   AST_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> armed); // R9

   AST_FIRST_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_fire && mode_q == SYNC_FIRST && !cfg_we) |=> !armed); // R8

   AST_STAB_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(stab_en) |-> $past(cfg_we)); // R3

endmodule

// File: rtl/csd_counter.sv
module csd_counter #(
   parameter int RATIO_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [RATIO_W-1:0] ratio_code,
   input  logic               sync_fire,
   output logic               strobe
);

   logic [RATIO_W-1:0] cnt_q;
   logic [RATIO_W-1:0] act_q;
   logic               wrap;

   assign wrap = (cnt_q == act_q);

   // The active ratio is reloaded only at a wrap or a sync reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= '0;
      end else if (sync_fire || wrap) begin
         cnt_q <= '0;
         act_q <= ratio_code;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign strobe = wrap;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= act_q); // R1

   AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_fire && ratio_code != '0) |=> !strobe); // R5

   AST_RATIO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe && !sync_fire) |=> $stable(act_q)); // R10

endmodule

// File: rtl/sync_clk_divider.sv
module sync_clk_divider #(
   parameter int RATIO_W     = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [RATIO_W+1:0] cfg_wdata,
   input  logic               sync_in,
   output logic               div_strobe,
   output logic               stab_en,
   output logic               sync_armed
);

   localparam int MAX_RATIO = 1 << RATIO_W;

   initial begin
      assert (RATIO_W >= 1 && RATIO_W <= 8)
         else $error("sync_clk_divider: RATIO_W out of range");
      assert (MAX_RATIO >= 2)
         else $error("sync_clk_divider: divider needs at least two ratios");
   end

   logic               sync_rise;
   logic               sync_fire;
   logic [RATIO_W-1:0] ratio_code;

   csd_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (sync_in),
      .rise_o   (sync_rise)
   );

   csd_ctrl #(.RATIO_W(RATIO_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_wdata  (cfg_wdata),
      .sync_rise  (sync_rise),
      .ratio_code (ratio_code),
      .sync_fire  (sync_fire),
      .armed      (sync_armed),
      .stab_en    (stab_en)
   );

   csd_counter #(.RATIO_W(RATIO_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .ratio_code (ratio_code),
      .sync_fire  (sync_fire),
      .strobe     (div_strobe)
   );

   AST_UNITY_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ratio_code) == '0 && $past(div_strobe)) |-> div_strobe); // R2

endmodule

// File: tb/sync_clk_divider_tb.sv
module sync_clk_divider_tb;

   localparam int S = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [4:0] cfg_wdata = '0;
   logic       sync_in = 1'b0;
   logic       div_strobe, stab_en, sync_armed;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit chk_on = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   sync_clk_divider u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .sync_in(sync_in), .div_strobe(div_strobe), .stab_en(stab_en),
      .sync_armed(sync_armed)
   );

   // ---------------- behavioural reference model ----------------
   bit sq[$];
   int m_cnt, m_act, m_ratio;
   bit m_en, m_first, m_armed;

   always @(posedge clk) begin
      bit rise, fire;
      if (!rst_n) begin
         sq = {};
         for (int i = 0; i <= S; i++) sq.push_back(1'b0);
         m_cnt = 0; m_act = 0; m_ratio = 0;
         m_en = 0; m_first = 0; m_armed = 0;
      end else begin
         rise = sq[S-1] && !sq[S];
         fire = rise && m_en && (!m_first || m_armed);
         if (fire || m_cnt == m_act) begin
            m_cnt = 0;
            m_act = m_ratio;
         end else begin
            m_cnt++;
         end
         if (cfg_we) m_armed = 1;
         else if (fire && m_first) m_armed = 0;
         if (cfg_we) begin
            m_ratio = int'(cfg_wdata[2:0]);
            m_en    = cfg_wdata[3];
            m_first = cfg_wdata[4];
         end
         sq.push_front(sync_in);
         void'(sq.pop_back());
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (chk_on) begin
         chk("R1 strobe vs model", int'(div_strobe), int'(m_cnt == m_act));
         chk("R3 stab_en vs model", int'(stab_en), int'(m_ratio != 0));
         chk("R9 sync_armed vs model", int'(sync_armed), int'(m_armed));
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         errors++;
         $display("FAIL watchdog actual %0d cycles expected below 20000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // ---------------- stimulus helpers ----------------
   function automatic logic [4:0] cw(input int code, input bit en, input bit first);
      return {first, en, 3'(code)};
   endfunction

   // Counts edges (sampled at falling edges) until the next strobe.
   // Any write or raise set up before the call is a one-edge write.
   task automatic next_strobe(output int n);
      n = 0;
      do begin
         @(negedge clk);
         cfg_we = 1'b0;
         n++;
      end while (!div_strobe && n < 64);
   endtask

   task automatic write_cfg(input logic [4:0] d);
      cfg_we = 1'b1;
      cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   initial begin
      int n;
      int low;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      chk_on = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 strobe after reset", int'(div_strobe), 1);
      chk("R11 stab_en after reset", int'(stab_en), 0);
      chk("R11 armed after reset", int'(sync_armed), 0);

      // R2 ratio 1 with sync toggling
      write_cfg(cw(0, 1, 0));
      low = 0;
      for (int i = 0; i < 16; i++) begin
         if (i % 3 == 0) sync_in = ~sync_in;
         @(negedge clk);
         if (!div_strobe) low++;
      end
      chk("R2 cycles without strobe at ratio 1", low, 0);

      // R1 / R3 divide by 4
      cfg_we = 1'b1; cfg_wdata = cw(3, 1, 0);
      next_strobe(n);
      chk("R3 stab_en after ratio 4 write", int'(stab_en), 1);
      for (int i = 0; i < 3; i++) begin
         next_strobe(n);
         chk("R1 period at ratio 4", n, 4);
      end

      // R5 / R4 / R7 every-edge mode
      sync_in = 1'b1;
      next_strobe(n);
      chk("R5 sync to strobe latency N=4", n, 6);
      next_strobe(n);
      chk("R4 held sync level is one event", n, 4);
      sync_in = 1'b0;
      next_strobe(n);
      chk("R4 period after sync drop", n, 4);
      sync_in = 1'b1;
      next_strobe(n);
      chk("R7 second edge also realigns", n, 6);
      sync_in = 1'b0;
      next_strobe(n);

      // R6 sync disabled
      write_cfg(cw(3, 0, 0));
      next_strobe(n);
      sync_in = 1'b1;
      next_strobe(n);
      chk("R6 disabled sync leaves phase", n, 4);
      sync_in = 1'b0;
      next_strobe(n);

      // R8 / R9 first-only mode
      write_cfg(cw(3, 1, 1));
      chk("R9 armed after write", int'(sync_armed), 1);
      next_strobe(n);
      sync_in = 1'b1;
      next_strobe(n);
      chk("R8 first edge after write applied", n, 6);
      chk("R9 disarmed after applied sync", int'(sync_armed), 0);
      sync_in = 1'b0;
      next_strobe(n);
      sync_in = 1'b1;
      next_strobe(n);
      chk("R8 later edge ignored", n, 4);
      sync_in = 1'b0;
      next_strobe(n);
      cfg_we = 1'b1; cfg_wdata = cw(3, 1, 1);
      next_strobe(n);
      chk("R9 re-armed by write", int'(sync_armed), 1);
      sync_in = 1'b1;
      next_strobe(n);
      chk("R8 re-armed edge applied", n, 6);
      sync_in = 1'b0;
      next_strobe(n);

      // R10 ratio change waits for wrap
      cfg_we = 1'b1; cfg_wdata = cw(1, 1, 0);
      next_strobe(n);
      chk("R10 old period completes (4)", n, 4);
      next_strobe(n);
      chk("R10 new ratio 2 period", n, 2);
      cfg_we = 1'b1; cfg_wdata = cw(7, 1, 0);
      next_strobe(n);
      chk("R10 old period completes (2)", n, 2);
      next_strobe(n);
      chk("R1 period at ratio 8", n, 8);
      sync_in = 1'b1;
      next_strobe(n);
      chk("R5 sync to strobe latency N=8", n, 10);
      sync_in = 1'b0;
      next_strobe(n);
      chk("R1 period at ratio 8 after sync", n, 8);

      // R3 back to ratio 1
      write_cfg(cw(0, 1, 0));
      chk("R3 stab_en low at ratio 1", int'(stab_en), 0);
      repeat (3) @(negedge clk);

      chk_on = 1'b0;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule